// File: doc/BRIEF.md
# Programmable Pin Input Debounce Filter

A per-pin input qualifier. A raw pin level is brought into the system clock domain through a flop synchronizer, then held against a programmable timeout before a change is allowed to reach the filtered output. The timeout is measured in ticks of a slow real-time clock of about 32.768 kHz. Those ticks reach the block as a single-cycle enable, `tick_i`.

The timeout is a small count multiplied by one of four tick units. The unit is picked by two select bits. One filter type removes short pulses in both directions. Two further types pass short pulses of one chosen polarity straight through and qualify only the opposite transition. This suits level-sensitive inputs that must not lose their assertion. A zero filter type turns the filter off, and the output then tracks the synchronized pin. Each change of the filtered level produces a one-cycle `change_o` pulse.

Top module: `pin_debounce_filter`

## Requirements
- R1: After reset, level_o and change_o are 0.
- R2: pin_i passes through two synchronizer flops. With filt_mode_i = 2'b00 (filter off), level_o equals the synchronized pin and changes two clock cycles after pin_i changes, with no timer involved.
- R3: The threshold is tmr_count_i times a unit selected by {unit_large_i, unit_fine_i}: 2'b00 gives 2 ticks, 2'b01 gives 8, 2'b10 gives 512 and 2'b11 gives 2048. In mode 2'b11 (both directions filtered), level_o takes the new level once the synchronized pin has differed from level_o for a threshold of consecutive ticks. With a tick every cycle, that is 2 + threshold cycles after pin_i changes.
- R4: If the synchronized pin returns to the current level_o before the threshold is reached, the tick count restarts from zero, and the pulse never appears on level_o.
- R5: Only cycles with tick_i = 1 advance the count. Without ticks, level_o holds its value indefinitely.
- R6: Mode 2'b01 keeps low pulses. A falling transition reaches level_o 3 cycles after pin_i falls, with no wait for ticks. A rising transition is qualified as in R3, and high pulses shorter than the threshold are removed.
- R7: Mode 2'b10 keeps high pulses. A rising transition reaches level_o after 3 cycles. A falling transition is qualified as in R3, and low pulses shorter than the threshold are removed.
- R8: With a filter active and tmr_count_i = 0, a change reaches level_o 3 cycles after pin_i changes.
- R9: Any change of tmr_count_i, the unit bits or filt_mode_i clears the tick count. Qualification then restarts under the new settings.
- R10: change_o is high for exactly the cycle in which level_o first shows a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable per slow-clock tick |
| pin_i | input | 1 | Raw pin level, asynchronous |
| tmr_count_i | input | TMR_W | Timeout count in units |
| unit_large_i | input | 1 | Unit select, upper bit |
| unit_fine_i | input | 1 | Unit select, lower bit |
| filt_mode_i | input | 2 | 00 off, 01 keep low pulses, 10 keep high pulses, 11 filter both |
| level_o | output | 1 | Filtered level |
| change_o | output | 1 | Pulse on each filtered change |

## Verification
The bench measures the exact cycle of each qualified edge for all four units and for the largest count. An off-by-one in the compare would show up as an edge one cycle early or late. A unit table that was wrong or in the wrong order would miss by hundreds of cycles.

Pulses shorter than the threshold are driven, followed by a pulse that dips for a single cycle just before qualifying. A counter that did not restart would let the dip-split pulse through early.

The bench holds tick_i low for a long stretch, exercises the preserve modes in both directions, and applies a zero count. A design that counted clocks instead of ticks, or swapped the preserved polarity, would move level_o at the wrong time.

It also changes the count in the middle of a qualification. A design that kept the old count would release the edge five cycles early.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  typedef enum logic [1:0] {
    FILT_OFF       = 2'b00,
    FILT_KEEP_LOW  = 2'b01,
    FILT_KEEP_HIGH = 2'b10,
    FILT_BOTH      = 2'b11
  } filt_mode_e;
endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dbf_limit.sv
module dbf_limit #(
  parameter int          TMR_W = 4,
  parameter int unsigned UNIT0 = 2,
  parameter int unsigned UNIT1 = 8,
  parameter int unsigned UNIT2 = 512,
  parameter int unsigned UNIT3 = 2048,
  parameter int          LIM_W = 15
) (
  input  logic [TMR_W-1:0] count_i,
  input  logic             large_i,
  input  logic             fine_i,
  output logic [LIM_W-1:0] lim_o
);
  logic [LIM_W-1:0] unit;

  always_comb begin
    unique case ({large_i, fine_i})
      2'b00:   unit = LIM_W'(UNIT0);
      2'b01:   unit = LIM_W'(UNIT1);
      2'b10:   unit = LIM_W'(UNIT2);
      default: unit = LIM_W'(UNIT3);
    endcase
  end

  assign lim_o = LIM_W'(count_i) * unit;
endmodule

// File: rtl/dbf_qualify.sv
module dbf_qualify
  import dbf_pkg::*;
#(
  parameter int LIM_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             sync_i,
  input  logic [LIM_W-1:0] lim_i,
  input  filt_mode_e       mode_i,
  input  logic             cfg_chg_i,
  output logic             state_o,
  output logic             level_o,
  output logic             change_o
);
  logic             state_q, last_q;
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] cnt_nxt;
  logic             differ, pass_now;

  assign differ  = sync_i != state_q;
  assign cnt_nxt = cnt_q + LIM_W'(1);

  // transitions toward the preserved polarity skip the timer
  always_comb begin
    unique case (mode_i)
      FILT_OFF:       pass_now = 1'b1;
      FILT_KEEP_LOW:  pass_now = ~sync_i;
      FILT_KEEP_HIGH: pass_now = sync_i;
      default:        pass_now = 1'b0;
    endcase
    if (lim_i == '0) pass_now = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (differ && pass_now) begin
      state_q <= sync_i;
      cnt_q   <= '0;
    end else if (!differ || cfg_chg_i) begin
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (cnt_nxt >= lim_i) begin
        state_q <= sync_i;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_nxt;
      end
    end
  end

  assign level_o = (mode_i == FILT_OFF) ? sync_i : state_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= level_o;

  assign change_o = level_o ^ last_q;
  assign state_o  = state_q;
endmodule

// File: rtl/pin_debounce_filter.sv
module pin_debounce_filter
  import dbf_pkg::*;
#(
  parameter int          TMR_W  = 4,
  parameter int          STAGES = 2,
  parameter int unsigned UNIT0  = 2,
  parameter int unsigned UNIT1  = 8,
  parameter int unsigned UNIT2  = 512,
  parameter int unsigned UNIT3  = 2048
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pin_i,
  input  logic [TMR_W-1:0] tmr_count_i,
  input  logic             unit_large_i,
  input  logic             unit_fine_i,
  input  logic [1:0]       filt_mode_i,
  output logic             level_o,
  output logic             change_o
);
  localparam int unsigned MAX_A    = (UNIT0 > UNIT1) ? UNIT0 : UNIT1;
  localparam int unsigned MAX_B    = (UNIT2 > UNIT3) ? UNIT2 : UNIT3;
  localparam int unsigned MAX_UNIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int          LIM_W    = $clog2(((2**TMR_W) - 1) * MAX_UNIT + 1);
  localparam int          CFG_W    = TMR_W + 4;

  logic             sync_q;
  logic [LIM_W-1:0] lim;
  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             cfg_chg;
  logic             filt_state;

  dbf_sync #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_q)
  );

  dbf_limit #(
    .TMR_W(TMR_W), .UNIT0(UNIT0), .UNIT1(UNIT1),
    .UNIT2(UNIT2), .UNIT3(UNIT3), .LIM_W(LIM_W)
  ) u_limit (
    .count_i(tmr_count_i),
    .large_i(unit_large_i),
    .fine_i (unit_fine_i),
    .lim_o  (lim)
  );

  assign cfg_now = {tmr_count_i, unit_large_i, unit_fine_i, filt_mode_i};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_now;

  assign cfg_chg = cfg_now != cfg_q;

  dbf_qualify #(.LIM_W(LIM_W)) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .sync_i   (sync_q),
    .lim_i    (lim),
    .mode_i   (filt_mode_e'(filt_mode_i)),
    .cfg_chg_i(cfg_chg),
    .state_o  (filt_state),
    .level_o  (level_o),
    .change_o (change_o)
  );
endmodule

// File: rtl/dbf_checker.sv
module dbf_checker
  import dbf_pkg::*;
#(
  parameter int TMR_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [TMR_W-1:0] tmr_count_i,
  input logic [1:0]       filt_mode_i,
  input logic             sync_i,
  input logic             state_i,
  input logic             level_o,
  input logic             change_o
);
  a_r5_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_mode_i == FILT_BOTH && !tick_i && tmr_count_i != '0) |=> state_i == $past(state_i));

  a_r6_low_passes_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_mode_i == FILT_KEEP_LOW && !sync_i && state_i) |=> !state_i);

  a_r7_high_passes_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_mode_i == FILT_KEEP_HIGH && sync_i && !state_i) |=> state_i);

  a_r3_takes_input_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != $past(state_i)) |-> state_i == $past(sync_i));

  a_r10_pulse_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != $past(level_o)) |-> change_o);
endmodule

bind pin_debounce_filter dbf_checker #(.TMR_W(TMR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .tmr_count_i(tmr_count_i),
  .filt_mode_i(filt_mode_i),
  .sync_i     (sync_q),
  .state_i    (filt_state),
  .level_o    (level_o),
  .change_o   (change_o)
);

// File: tb/pin_debounce_filter_test.sv
module pin_debounce_filter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       pin_i = 1'b0;
  logic [3:0] tmr_count_i = '0;
  logic       unit_large_i = 1'b0;
  logic       unit_fine_i = 1'b0;
  logic [1:0] filt_mode_i = 2'b00;
  logic       level_o, change_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  pin_debounce_filter uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .pin_i(pin_i),
    .tmr_count_i(tmr_count_i), .unit_large_i(unit_large_i),
    .unit_fine_i(unit_fine_i), .filt_mode_i(filt_mode_i),
    .level_o(level_o), .change_o(change_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic settle(input logic v, input logic [3:0] cnt,
                        input logic lg, input logic fn, input logic [1:0] md);
    filt_mode_i = 2'b00;
    pin_i = v;
    repeat (4) @(negedge clk_i);
    tmr_count_i = cnt; unit_large_i = lg; unit_fine_i = fn; filt_mode_i = md;
    repeat (3) @(negedge clk_i);
  endtask

  // drive v now; level_o must show it exactly n cycles later
  task automatic expect_edge(input string req, input logic v, input int n);
    pin_i = v;
    repeat (n - 1) @(negedge clk_i);
    chk(req, level_o, ~v);
    chk(req, change_o, 1'b0);
    @(negedge clk_i);
    chk(req, level_o, v);
    chk({req, " pulse R10"}, change_o, 1'b1);
    @(negedge clk_i);
    chk({req, " pulse end R10"}, change_o, 1'b0);
  endtask

  task automatic pulse_blocked(input string req, input logic v, input int len);
    int bad = 0;
    pin_i = v;
    repeat (len) @(negedge clk_i);
    pin_i = ~v;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (level_o !== ~v || change_o !== 1'b0) bad++;
    end
    chk(req, bad == 0, 1'b1);
  endtask

  task automatic t_reset;
    chk("R1 level", level_o, 1'b0);
    chk("R1 change", change_o, 1'b0);
  endtask

  task automatic t_bypass;
    settle(1'b0, 4'd0, 1'b0, 1'b0, 2'b00);
    expect_edge("R2 rise", 1'b1, 2);
    expect_edge("R2 fall", 1'b0, 2);
  endtask

  task automatic t_units;
    settle(1'b0, 4'd1, 1'b0, 1'b0, 2'b11);
    expect_edge("R3 unit00 rise", 1'b1, 4);
    expect_edge("R3 unit00 fall", 1'b0, 4);
    settle(1'b0, 4'd3, 1'b0, 1'b1, 2'b11);
    expect_edge("R3 unit01", 1'b1, 26);
    settle(1'b0, 4'd1, 1'b1, 1'b0, 2'b11);
    expect_edge("R3 unit10", 1'b1, 514);
    settle(1'b0, 4'd2, 1'b1, 1'b1, 2'b11);
    expect_edge("R3 unit11", 1'b1, 4098);
    settle(1'b0, 4'd15, 1'b1, 1'b1, 2'b11);
    expect_edge("R3 max count", 1'b1, 30722);
  endtask

  task automatic t_glitch;
    settle(1'b0, 4'd4, 1'b0, 1'b0, 2'b11);
    pulse_blocked("R4 short high", 1'b1, 5);
    pin_i = 1'b1;
    repeat (5) @(negedge clk_i);
    pin_i = 1'b0;
    @(negedge clk_i);
    expect_edge("R4 restart", 1'b1, 10);
    pulse_blocked("R4 short low", 1'b0, 5);
  endtask

  task automatic t_tick;
    settle(1'b0, 4'd1, 1'b0, 1'b0, 2'b11);
    tick_i = 1'b0;
    pin_i = 1'b1;
    repeat (40) @(negedge clk_i);
    chk("R5 held", level_o, 1'b0);
    tick_i = 1'b1;
    @(negedge clk_i);
    chk("R5 one tick", level_o, 1'b0);
    @(negedge clk_i);
    chk("R5 two ticks", level_o, 1'b1);
  endtask

  task automatic t_keep_low;
    settle(1'b1, 4'd4, 1'b0, 1'b0, 2'b01);
    expect_edge("R6 fall fast", 1'b0, 3);
    pulse_blocked("R6 high glitch", 1'b1, 5);
    expect_edge("R6 rise slow", 1'b1, 10);
  endtask

  task automatic t_keep_high;
    settle(1'b0, 4'd4, 1'b0, 1'b0, 2'b10);
    expect_edge("R7 rise fast", 1'b1, 3);
    pulse_blocked("R7 low glitch", 1'b0, 5);
    expect_edge("R7 fall slow", 1'b0, 10);
  endtask

  task automatic t_zero;
    settle(1'b0, 4'd0, 1'b0, 1'b0, 2'b11);
    expect_edge("R8 rise", 1'b1, 3);
    expect_edge("R8 fall", 1'b0, 3);
  endtask

  task automatic t_cfg;
    settle(1'b0, 4'd4, 1'b0, 1'b0, 2'b11);
    pin_i = 1'b1;
    repeat (6) @(negedge clk_i);
    tmr_count_i = 4'd5;
    repeat (10) @(negedge clk_i);
    chk("R9 not yet", level_o, 1'b0);
    @(negedge clk_i);
    chk("R9 after restart", level_o, 1'b1);
    chk("R9 pulse R10", change_o, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_bypass();
    t_units();
    t_glitch();
    t_tick();
    t_keep_low();
    t_keep_high();
    t_zero();
    t_cfg();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule